// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Resolver

This block decides, on every clock, which one of several pending interrupt requests the processor should take next, and presents it as a valid flag plus an 8-bit vector type. There are two tiers. The upper tier holds three sources: a single-step trace request, a nonmaskable interrupt, and a software exception that carries its own 3-bit type number. The lower tier holds a parameterised number of maskable hardware lines.

Each hardware line has a mask bit and a 3-bit urgency level. A line is first ranked by its level, where 0 is the most urgent. Lines that share a level are then ranked by fixed position, and a lower index wins. Hardware requests are captured on a rising edge into a pending flag. That flag is cleared when the processor pulses the acknowledge while that line is the presented winner.

A single write port loads the mask bit and the level of one line per cycle. A global enable hides the whole hardware tier. The chosen winner is registered, so the outputs change one clock after the pending and configuration state they are computed from.

Top module: `irq_resolver`

## Requirements
- R1: After synchronous reset, `irq_valid` is 0, no hardware line is pending, every mask bit is 0 and every level is 7. With no writes, hardware lines are therefore ranked purely by index.
- R2: Upper-tier inputs are level requests and are not latched. Trace wins with vector 1. Otherwise the nonmaskable request wins with vector 2. Otherwise the software request wins with vector equal to `swx_type` zero-extended to 8 bits.
- R3: While any upper-tier input is high, the presented winner is an upper-tier source, whatever hardware lines are pending.
- R4: `int_en` = 0 removes every hardware line from arbitration without clearing its pending flag. It has no effect on the upper tier.
- R5: A hardware line becomes pending on a 0-to-1 transition of its `hw_req` bit. A line held high does not become pending again after it is acknowledged.
- R6: Among eligible hardware lines, the one with the numerically smallest level wins. Hardware line i is presented as vector 8+i.
- R7: Among eligible hardware lines that share the smallest level, the lowest index wins.
- R8: A line whose mask bit is 1 takes no part in arbitration, but its pending flag is kept. It competes again once it is unmasked.
- R9: A high `ack` at a clock edge clears only the pending flag of the hardware line being presented at that edge. With an upper-tier winner, or with `irq_valid` low, `ack` changes nothing.
- R10: `irq_valid` and `irq_vec` are registered. A request, acknowledge or enable change at a clock edge is reflected in the outputs from that edge onward.
- R11: When `wr_en` is high at an edge, line `wr_sel` loads `wr_mask` and `wr_lvl`. Arbitration uses the new values from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_req | input | 1 | Single-step trace request (level) |
| nmi_req | input | 1 | Nonmaskable interrupt request (level) |
| swx_req | input | 1 | Software exception request (level) |
| swx_type | input | 3 | Vector type of the software exception |
| hw_req | input | N_SRC | Maskable hardware request lines, edge captured |
| int_en | input | 1 | Global enable for the hardware tier |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | IDX_W | Hardware line addressed by the write |
| wr_mask | input | 1 | Mask bit to load |
| wr_lvl | input | 3 | Urgency level to load, 0 most urgent |
| ack | input | 1 | Processor takes the presented winner |
| irq_valid | output | 1 | A winner is presented |
| irq_vec | output | 8 | Vector type of the winner |

## Verification
The hardest state to reach from the ports is several hardware lines pending at once with differing levels, followed by their draining in the correct order. Each line's pending flag can only be set by a rising edge. The bench therefore raises a whole request pattern in one cycle and then drops it. It acknowledges the winners one by one and compares each winner with a minimum computed arithmetically in the bench. It does this for every nonempty pattern of a four-line configuration and for eight level assignments, including ties and a group lowered to level 6. Directed sequences cover the corners: an acknowledge that lands on an upper-tier winner, a masked line that is pending, and a line whose request is held high.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LVL_W = 3;
    localparam int VEC_W = 8;
    localparam int SWX_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam lvl_t LVL_RESET = '1;

    typedef enum logic [2:0] {
        TIER_NONE  = 3'd0,
        TIER_TRACE = 3'd1,
        TIER_NMI   = 3'd2,
        TIER_SWX   = 3'd3,
        TIER_HW    = 3'd4
    } tier_e;

    typedef struct packed {
        logic  valid;
        tier_e tier;
        vec_t  vec;
    } win_t;

    localparam win_t WIN_IDLE = '{valid: 1'b0, tier: TIER_NONE, vec: '0};

    // Fixed order of the upper tier: trace, then nonmaskable, then software.
    function automatic win_t nm_pick(
        input logic             trace,
        input logic             nmi,
        input logic             swx,
        input logic [SWX_W-1:0] swx_ty,
        input vec_t             trace_vec,
        input vec_t             nmi_vec
    );
        win_t w;
        w = WIN_IDLE;
        if (trace) begin
            w = '{valid: 1'b1, tier: TIER_TRACE, vec: trace_vec};
        end else if (nmi) begin
            w = '{valid: 1'b1, tier: TIER_NMI, vec: nmi_vec};
        end else if (swx) begin
            w = '{valid: 1'b1, tier: TIER_SWX, vec: vec_t'(swx_ty)};
        end
        return w;
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic clr,
    input  logic wr,
    input  logic wr_mask,
    input  lvl_t wr_lvl,
    output logic pend_nxt,
    output logic mask_q,
    output lvl_t lvl_q
);

    logic prev_q;
    logic pend_q;

    // A new rising edge takes precedence over a clear in the same cycle.
    assign pend_nxt = (pend_q & ~clr) | (req & ~prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            mask_q <= 1'b0;
            lvl_q  <= LVL_RESET;
        end else begin
            prev_q <= req;
            pend_q <= pend_nxt;
            if (wr) begin
                mask_q <= wr_mask;
                lvl_q  <= wr_lvl;
            end
        end
    end

    // R5: a rising request always leaves the line pending
    assert_rise_pends_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |=> pend_q);

    // R8: masking never drops a pending flag
    assert_mask_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (mask_q && pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/irq_hw_arb.sv
module irq_hw_arb
    import irq_pkg::*;
#(
    parameter  int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] elig,
    input  lvl_t             lvl [N_SRC],
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    lvl_t best;

    // Scan from the highest index down; "<=" lets a lower index take a tie.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = LVL_RESET;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!any || lvl[i] <= best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = lvl[i];
            end
        end
    end

    always_comb begin
        if (any) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (elig[i]) begin
                    assert_min_level_R6: assert (lvl[i] >= best);
                    assert_tie_low_R7: assert ((lvl[i] != best) || (IDX_W'(i) >= idx));
                end
            end
        end
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
#(
    parameter  int N_SRC     = 8,
    parameter  int HW_BASE   = 8,
    parameter  int TRACE_VEC = 1,
    parameter  int NMI_VEC   = 2,
    localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trace_req,
    input  logic             nmi_req,
    input  logic             swx_req,
    input  logic [SWX_W-1:0] swx_type,
    input  logic [N_SRC-1:0] hw_req,
    input  logic             int_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic             wr_mask,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic             ack,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec
);

    logic [N_SRC-1:0] pend_nxt;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] clr;
    logic [N_SRC-1:0] wr_hit;
    logic [N_SRC-1:0] elig;
    lvl_t             lvl_q [N_SRC];

    win_t             win_d, win_q;
    logic [IDX_W-1:0] idx_q;
    logic             hw_any;
    logic [IDX_W-1:0] hw_idx;

    logic take_hw;
    assign take_hw = ack && win_q.valid && (win_q.tier == TIER_HW);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign clr[g]    = take_hw && (idx_q == IDX_W'(g));
        assign wr_hit[g] = wr_en && (wr_sel == IDX_W'(g));

        irq_src_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .req      (hw_req[g]),
            .clr      (clr[g]),
            .wr       (wr_hit[g]),
            .wr_mask  (wr_mask),
            .wr_lvl   (wr_lvl),
            .pend_nxt (pend_nxt[g]),
            .mask_q   (mask_q[g]),
            .lvl_q    (lvl_q[g])
        );
    end

    // Arbitrate on next-cycle pending state so an acknowledged line is gone
    // from the very register update that consumes it.
    assign elig = pend_nxt & ~mask_q & {N_SRC{int_en}};

    irq_hw_arb #(.N_SRC(N_SRC)) u_arb (
        .elig (elig),
        .lvl  (lvl_q),
        .any  (hw_any),
        .idx  (hw_idx)
    );

    always_comb begin
        win_d = nm_pick(trace_req, nmi_req, swx_req, swx_type,
                        vec_t'(TRACE_VEC), vec_t'(NMI_VEC));
        if (!win_d.valid && hw_any) begin
            win_d = '{valid: 1'b1, tier: TIER_HW,
                      vec: vec_t'(HW_BASE) + vec_t'(hw_idx)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= WIN_IDLE;
            idx_q <= '0;
        end else begin
            win_q <= win_d;
            idx_q <= hw_idx;
        end
    end

    assign irq_valid = win_q.valid;
    assign irq_vec   = win_q.vec;

    // R2: trace outranks everything
    assert_trace_first_R2: assert property (@(posedge clk) disable iff (rst)
        trace_req |=> (irq_valid && irq_vec == vec_t'(TRACE_VEC)));

    // R2: nonmaskable is second
    assert_nmi_second_R2: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !trace_req) |=> (irq_valid && irq_vec == vec_t'(NMI_VEC)));

    // R3: a software exception beats any hardware line
    assert_swx_over_hw_R3: assert property (@(posedge clk) disable iff (rst)
        (swx_req && !trace_req && !nmi_req)
            |=> (irq_valid && irq_vec == vec_t'($past(swx_type))));

    // R4: with the enable low only the upper tier may be presented
    assert_gate_hw_R4: assert property (@(posedge clk) disable iff (rst)
        (!int_en && !trace_req && !nmi_req && !swx_req) |=> !irq_valid);

endmodule

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;

    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          trace_req, nmi_req, swx_req;
    logic [2:0]    swx_type;
    logic [NS-1:0] hw_req;
    logic          int_en, wr_en, wr_mask, ack;
    logic [1:0]    wr_sel;
    logic [2:0]    wr_lvl;
    logic          irq_valid;
    logic [7:0]    irq_vec;

    int ntests = 0;
    int nfail  = 0;
    int lv [NS];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_resolver #(.N_SRC(NS)) u0 (
        .clk(clk), .rst(rst), .trace_req(trace_req), .nmi_req(nmi_req),
        .swx_req(swx_req), .swx_type(swx_type), .hw_req(hw_req),
        .int_en(int_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_mask(wr_mask),
        .wr_lvl(wr_lvl), .ack(ack), .irq_valid(irq_valid), .irq_vec(irq_vec)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, bit ev, int evec);
        ntests++;
        if (irq_valid !== ev || (ev && irq_vec !== 8'(evec))) begin
            nfail++;
            $display("FAIL %s: actual valid=%0b vec=%0d, expected valid=%0b vec=%0d",
                     tag, irq_valid, irq_vec, ev, evec);
        end
    endtask

    task automatic write_cfg(int sel, bit m, int l);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_mask = m; wr_lvl = 3'(l);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    // Smallest level first, then smallest index (R6, R7).
    function automatic int best_of(int m);
        int b = -1;
        for (int i = 0; i < NS; i++)
            if (m[i] && (b < 0 || lv[i] < lv[b])) b = i;
        return b;
    endfunction

    task automatic sweep_pattern(int pat);
        int m = pat;
        hw_req = NS'(pat);
        tick();
        hw_req = '0;
        for (int k = 0; k <= NS; k++) begin
            int w = best_of(m);
            if (w < 0) begin
                check("R6/R7 drained", 1'b0, 0);
                break;
            end
            check("R6/R7 sweep winner", 1'b1, 8 + w);
            pulse_ack();      // R9
            m[w] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            ntests++; nfail++;
            $display("FAIL R10 watchdog: actual hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; trace_req = 0; nmi_req = 0; swx_req = 0; swx_type = '0;
        hw_req = '0; int_en = 1'b1; wr_en = 0; wr_sel = '0; wr_mask = 0;
        wr_lvl = '0; ack = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 reset idle", 1'b0, 0);

        // Sweep: cfg 0 uses reset levels (R1), others are written (R11).
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < NS; i++) begin
                if (c == 0)      lv[i] = 7;
                else if (c == 6) lv[i] = (i >= 2) ? 6 : 7;
                else if (c == 7) lv[i] = 4;
                else             lv[i] = (c * 3 + i * 5) % 8;
                if (c != 0) write_cfg(i, 1'b0, lv[i]);
            end
            for (int p = 1; p < (1 << NS); p++) sweep_pattern(p);
        end
        for (int i = 0; i < NS; i++) begin
            lv[i] = 7;
            write_cfg(i, 1'b0, 7);
        end

        // R2 upper-tier order
        trace_req = 1; nmi_req = 1; swx_req = 1; swx_type = 3'd5;
        tick(); check("R2 trace first", 1'b1, 1);
        trace_req = 0;
        tick(); check("R2 nmi second", 1'b1, 2);
        nmi_req = 0;
        tick(); check("R2 swx third", 1'b1, 5);
        for (int t = 0; t < 8; t++) begin
            swx_type = 3'(t);
            tick(); check("R2 swx type", 1'b1, t);
        end
        swx_req = 0;
        tick(); check("R2 level not latched", 1'b0, 0);

        // R3 upper tier over pending hardware
        hw_req = 4'b0011; tick(); hw_req = '0;
        check("R3 hw alone", 1'b1, 8);
        swx_req = 1; swx_type = 3'd3;
        tick(); check("R3 swx over hw", 1'b1, 3);
        nmi_req = 1;
        tick(); check("R3 nmi over hw", 1'b1, 2);

        // R9 ack during upper-tier winner leaves hw pending
        pulse_ack();
        nmi_req = 0; swx_req = 0;
        check("R9 ack on nmi", 1'b1, 2);
        tick(); check("R9 hw untouched", 1'b1, 8);
        pulse_ack(); check("R9 clears only winner", 1'b1, 9);
        pulse_ack(); check("R9 drained", 1'b0, 0);
        pulse_ack(); check("R9 ack while idle", 1'b0, 0);

        // R4 global enable
        hw_req = 4'b0001; tick(); hw_req = '0;
        check("R4 hw visible", 1'b1, 8);
        int_en = 0;
        tick(); check("R4 hw hidden", 1'b0, 0);
        nmi_req = 1;
        tick(); check("R4 nmi ignores enable", 1'b1, 2);
        nmi_req = 0;
        tick(); check("R4 still hidden", 1'b0, 0);
        int_en = 1;
        tick(); check("R4 pending kept", 1'b1, 8);
        pulse_ack(); check("R4 drained", 1'b0, 0);

        // R5 held request does not re-pend
        hw_req = 4'b0100; tick();
        check("R5 rise pends", 1'b1, 10);
        pulse_ack(); check("R5 held high no re-pend", 1'b0, 0);
        tick(); check("R5 still idle", 1'b0, 0);
        hw_req = '0; tick();
        hw_req = 4'b0100; tick(); hw_req = '0;
        check("R5 new rise", 1'b1, 10);
        pulse_ack(); check("R5 drained", 1'b0, 0);

        // R8 mask keeps pending
        write_cfg(0, 1'b1, 7);
        hw_req = 4'b0011; tick(); hw_req = '0;
        check("R8 masked skipped", 1'b1, 9);
        pulse_ack(); check("R8 masked not shown", 1'b0, 0);
        write_cfg(0, 1'b0, 7);
        check("R11 write not yet used", 1'b0, 0);
        tick(); check("R8 unmasked returns", 1'b1, 8);
        pulse_ack(); check("R8 drained", 1'b0, 0);

        // R10 registered output, R11 level write latency
        hw_req = 4'b0011;
        #1 check("R10 no combinational path", 1'b0, 0);
        tick(); hw_req = '0;
        check("R10 one clock later", 1'b1, 8);
        write_cfg(1, 1'b0, 2);
        check("R11 old level in use", 1'b1, 8);
        tick(); check("R11 new level wins", 1'b1, 9);
        pulse_ack(); check("R11 next", 1'b1, 8);
        pulse_ack(); check("R11 drained", 1'b0, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule